// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

This block is a watchdog timer set up through one 8-bit configuration register. The register holds a two-bit resolution, a five-bit multiplier and a steering bit. The countdown advances on a 16 Hz tick strobe that is produced outside the block, so one count is one sixteenth of a second. The countdown lasts four raised to the resolution, times the multiplier, in ticks.

When the countdown runs out, the block sets an expiry flag. The steering bit then selects one of two actions. One action is a one-cycle system-reset request. With that request the block also clears its own configuration register and pulses a strobe that clears a control bit held in a neighbouring register. The other action is a one-cycle interrupt pulse.

Software keeps the watchdog alive in one of two ways. It can rewrite the configuration, which also clears the flag. It can read the flag port, and that read reloads the countdown from the configuration currently held.

Top module: `wdog_steer`

## Requirements
- R1: Configuration bits [1:0] are the resolution `res`, bits [6:2] the multiplier `mul` and bit 7 the steering bit. After the countdown is loaded, expiry happens on the (4^res × mul)-th accepted tick. Its pulse outputs are high in the clock cycle that follows the edge at which that tick is sampled.
- R2: With the steering bit at 0, an expiry sets the flag and raises `irqPulse` for exactly one cycle. `sysRstReq` and `ctrlBitClr` stay low.
- R3: With the steering bit at 1, an expiry sets the flag and raises `sysRstReq` and `ctrlBitClr` together for exactly one cycle. `irqPulse` stays low, and `wdogCfg` reads 0x00 from that cycle on.
- R4: A multiplier of zero disables the watchdog: no number of ticks produces an expiry.
- R5: A write (`cfgWrEn`) stores `cfgWrData`, clears the flag and restarts the countdown from the new value. All three take effect one cycle later.
- R6: A flag read (`flagRdEn`) reloads the countdown from the stored configuration and restarts it. `flagRdData` carries the flag in bit 7, and bits 6:0 are always zero.
- R7: After an expiry of either kind the countdown is idle. No further expiry happens until the next write or flag read.
- R8: Once set, the flag stays set through ticks and flag reads until the next configuration write.
- R9: A write takes priority over a flag read, and a flag read takes priority over a tick. A tick in a cycle that has a write or a read is not counted.
- R10: After reset the configuration is 0x00, the flag is clear, all pulse outputs are low and the countdown is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 16 Hz |
| cfgWrEn | input | 1 | Write strobe for the configuration register |
| cfgWrData | input | 8 | Configuration value to write |
| flagRdEn | input | 1 | Flag read strobe; reloads the countdown |
| flagRdData | output | 8 | Flag in bit 7, zeros below |
| wdogCfg | output | 8 | Current configuration register value |
| sysRstReq | output | 1 | One-cycle system-reset request |
| ctrlBitClr | output | 1 | One-cycle clear strobe for the neighbouring control bit |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
Every result of this block is registered, so each one is due exactly one clock cycle after the stimulus that causes it. A write shows on `wdogCfg` and on the flag in the following cycle. An expiry pulse appears in the cycle after its final tick is sampled. The bench drives inputs at the falling edge and samples all outputs one nanosecond after the next rising edge. At that same point it advances a spec-level model by one cycle, so the expected value and the result it is compared with belong to the same edge. Directed sequences count ticks to one short of the timeout and to the timeout itself, and put collisions of write, read and tick in the same cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Strobes from the control unit to the datapath; at most one is set per cycle.
  typedef struct packed {
    logic ldNew;   // load a freshly written configuration
    logic ldCur;   // reload the countdown from the stored configuration
    logic dec;     // count one tick
    logic expire;  // countdown ran out on this tick
  } wdStrobes_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       cfgWrEn,
  input  logic       flagRdEn,
  input  logic       tick,
  input  logic       active,
  input  logic       cntIsOne,
  output wdStrobes_t strobes
);
  logic tickTaken;

  // A write wins over a read, and a read wins over a tick.
  assign tickTaken = tick && active && !cfgWrEn && !flagRdEn;

  always_comb begin
    strobes        = '0;
    strobes.ldNew  = cfgWrEn;
    strobes.ldCur  = flagRdEn && !cfgWrEn;
    strobes.dec    = tickTaken && !cntIsOne;
    strobes.expire = tickTaken && cntIsOne;
  end
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int RES_W = 2,
  parameter int MUL_W = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  wdStrobes_t                 strobes,
  input  logic [RES_W+MUL_W:0]       cfgWrData,
  output logic                       active,
  output logic                       cntIsOne,
  output logic [RES_W+MUL_W:0]       cfgReg,
  output logic                       flag,
  output logic                       rstPulse,
  output logic                       clrPulse,
  output logic                       irqPulse
);
  localparam int DATA_W  = RES_W + MUL_W + 1;
  localparam int STEER_B = DATA_W - 1;
  localparam int CNT_W   = MUL_W + 2 * ((1 << RES_W) - 1);

  logic [CNT_W-1:0] count;

  function automatic logic [CNT_W-1:0] timeoutOf(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] mul;
    mul = CNT_W'(v[RES_W +: MUL_W]);
    return mul << (2 * v[RES_W-1:0]);
  endfunction

  function automatic logic armedBy(input logic [DATA_W-1:0] v);
    return v[RES_W +: MUL_W] != '0;
  endfunction

  assign cntIsOne = (count == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg   <= '0;
      count    <= '0;
      active   <= 1'b0;
      flag     <= 1'b0;
      rstPulse <= 1'b0;
      clrPulse <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      rstPulse <= 1'b0;
      clrPulse <= 1'b0;
      irqPulse <= 1'b0;
      if (strobes.ldNew) begin
        cfgReg <= cfgWrData;
        flag   <= 1'b0;
        count  <= timeoutOf(cfgWrData);
        active <= armedBy(cfgWrData);
      end else if (strobes.ldCur) begin
        count  <= timeoutOf(cfgReg);
        active <= armedBy(cfgReg);
      end else if (strobes.expire) begin
        flag   <= 1'b1;
        active <= 1'b0;
        if (cfgReg[STEER_B]) begin
          cfgReg   <= '0;
          rstPulse <= 1'b1;
          clrPulse <= 1'b1;
        end else begin
          irqPulse <= 1'b1;
        end
      end else if (strobes.dec) begin
        count <= count - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int RES_W = 2,
  parameter int MUL_W = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tick,
  input  logic                   cfgWrEn,
  input  logic [RES_W+MUL_W:0]   cfgWrData,
  input  logic                   flagRdEn,
  output logic [RES_W+MUL_W:0]   flagRdData,
  output logic [RES_W+MUL_W:0]   wdogCfg,
  output logic                   sysRstReq,
  output logic                   ctrlBitClr,
  output logic                   irqPulse
);
  localparam int DATA_W = RES_W + MUL_W + 1;

  wdStrobes_t strobes;
  logic       active;
  logic       cntIsOne;
  logic       flag;

  wdog_ctrl i_ctrl (
    .cfgWrEn (cfgWrEn),
    .flagRdEn(flagRdEn),
    .tick    (tick),
    .active  (active),
    .cntIsOne(cntIsOne),
    .strobes (strobes)
  );

  wdog_dp #(.RES_W(RES_W), .MUL_W(MUL_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgWrData(cfgWrData),
    .active   (active),
    .cntIsOne (cntIsOne),
    .cfgReg   (wdogCfg),
    .flag     (flag),
    .rstPulse (sysRstReq),
    .clrPulse (ctrlBitClr),
    .irqPulse (irqPulse)
  );

  assign flagRdData = {flag, {(DATA_W-1){1'b0}}};
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              cfgWrEn,
  input logic [DATA_W-1:0] cfgWrData,
  input logic              flagRdEn,
  input logic [DATA_W-1:0] flagRdData,
  input logic [DATA_W-1:0] wdogCfg,
  input logic              sysRstReq,
  input logic              ctrlBitClr,
  input logic              irqPulse
);
  // R2: an interrupt expiry sets the flag and never comes with a reset request
  a_r2_irq_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (flagRdData[DATA_W-1] && !sysRstReq && !ctrlBitClr));

  // R3: a reset expiry clears the configuration and strobes the control-bit clear
  a_r3_rst_clears_cfg: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (wdogCfg == '0 && ctrlBitClr && flagRdData[DATA_W-1]));

  // R3: the reset request lasts one cycle
  a_r3_rst_single: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  // R5: a write lands in the register and clears the flag one cycle later
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (wdogCfg == $past(cfgWrData) && !flagRdData[DATA_W-1]));

  // R6: only bit 7 of the flag port carries information
  a_r6_flag_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    flagRdData[DATA_W-2:0] == '0);

  // R8: the flag holds until a write
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagRdData[DATA_W-1] && !cfgWrEn) |=> flagRdData[DATA_W-1]);

  // R9: a cycle with a write or a read never produces an expiry
  a_r9_access_blocks_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn || flagRdEn) |=> !(irqPulse || sysRstReq));

  // R1: every expiry follows a sampled tick
  a_r1_expiry_needs_tick: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse || sysRstReq) |-> $past(tick));
endmodule

bind wdog_steer wdog_steer_chk #(.DATA_W(RES_W + MUL_W + 1)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .cfgWrEn   (cfgWrEn),
  .cfgWrData (cfgWrData),
  .flagRdEn  (flagRdEn),
  .flagRdData(flagRdData),
  .wdogCfg   (wdogCfg),
  .sysRstReq (sysRstReq),
  .ctrlBitClr(ctrlBitClr),
  .irqPulse  (irqPulse)
);

// File: tb/test_wdog_steer.sv
module test_wdog_steer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       flagRdEn = 1'b0;
  logic [7:0] flagRdData;
  logic [7:0] wdogCfg;
  logic       sysRstReq;
  logic       ctrlBitClr;
  logic       irqPulse;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  // spec-level model state
  logic [7:0] mCfg = 8'h00;
  int         mCnt = 0;
  logic       mAct = 1'b0;
  logic       mFlag = 1'b0;
  logic       mRst = 1'b0;
  logic       mIrq = 1'b0;

  wdog_steer i_wdog_steer (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .flagRdEn(flagRdEn), .flagRdData(flagRdData),
    .wdogCfg(wdogCfg), .sysRstReq(sysRstReq), .ctrlBitClr(ctrlBitClr),
    .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d cycles, expected < %0d", cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // R1: timeout in ticks from the field layout res=[1:0], mul=[6:2]
  function automatic int timeoutTicks(input logic [7:0] v);
    return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic modelStep(input logic w, input logic [7:0] d, input logic r, input logic t);
    mRst = 1'b0;
    mIrq = 1'b0;
    if (w) begin
      mCfg = d; mFlag = 1'b0; mCnt = timeoutTicks(d); mAct = (d[6:2] != 0);
    end else if (r) begin
      mCnt = timeoutTicks(mCfg); mAct = (mCfg[6:2] != 0);
    end else if (t && mAct) begin
      if (mCnt == 1) begin
        mFlag = 1'b1; mAct = 1'b0;
        if (mCfg[7]) begin mCfg = 8'h00; mRst = 1'b1; end
        else mIrq = 1'b1;
      end else begin
        mCnt = mCnt - 1;
      end
    end
  endtask

  task automatic compareAll();
    chk("R2 irqPulse", int'(irqPulse), int'(mIrq));
    chk("R3 sysRstReq", int'(sysRstReq), int'(mRst));
    chk("R3 ctrlBitClr", int'(ctrlBitClr), int'(mRst));
    chk("R5 wdogCfg", int'(wdogCfg), int'(mCfg));
    chk("R8 flagRdData", int'(flagRdData), int'({mFlag, 7'b0}));
  endtask

  // drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic t);
    cfgWrEn = w; cfgWrData = d; flagRdEn = r; tick = t;
    @(posedge clk); #1;
    modelStep(w, d, r, t);
    compareAll();
    @(negedge clk);
    cfgWrEn = 1'b0; flagRdEn = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 cfg after reset", int'(wdogCfg), 0);
    chk("R10 flag after reset", int'(flagRdData), 0);
    chk("R10 pulses after reset", int'({sysRstReq, ctrlBitClr, irqPulse}), 0);
    rstN = 1'b1;
    @(negedge clk);
    ticks(5);
    chk("R10 idle after reset", int'({sysRstReq, irqPulse}), 0);

    // R1/R2: res=1 mul=1 -> 4 ticks, interrupt steering
    step(1'b1, 8'h05, 1'b0, 1'b0);
    ticks(3);
    chk("R1 no expiry one tick early", int'(irqPulse), 0);
    ticks(1);
    chk("R1 expiry on 4th tick", int'(irqPulse), 1);
    chk("R2 flag set on irq expiry", int'(flagRdData), 8'h80);
    chk("R2 no reset on irq expiry", int'(sysRstReq), 0);
    ticks(1);
    chk("R2 irq one cycle", int'(irqPulse), 0);

    // R7: idle after expiry
    ticks(20);
    chk("R7 no re-expiry while idle", int'(irqPulse), 0);

    // R6/R8: flag read keeps flag and reloads the countdown
    step(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R8 flag survives read", int'(flagRdData), 8'h80);
    ticks(3);
    chk("R6 reload not yet expired", int'(irqPulse), 0);
    ticks(1);
    chk("R6 reload expires after 4 ticks", int'(irqPulse), 1);

    // R5/R3: write clears flag, reset steering with 2 ticks
    step(1'b1, 8'h88, 1'b0, 1'b0);
    chk("R5 flag cleared by write", int'(flagRdData), 0);
    chk("R5 cfg written", int'(wdogCfg), 8'h88);
    ticks(2);
    chk("R3 reset request", int'(sysRstReq), 1);
    chk("R3 control clear strobe", int'(ctrlBitClr), 1);
    chk("R3 cfg cleared", int'(wdogCfg), 0);
    chk("R3 no irq", int'(irqPulse), 0);
    ticks(1);
    chk("R3 reset request one cycle", int'(sysRstReq), 0);
    step(1'b0, 8'h00, 1'b1, 1'b0);
    ticks(10);
    chk("R7 cleared cfg stays idle after read", int'(sysRstReq | irqPulse), 0);

    // R4: multiplier zero never expires
    step(1'b1, 8'h83, 1'b0, 1'b0);
    ticks(300);
    chk("R4 disabled watchdog never expires", int'(sysRstReq | irqPulse), 0);

    // R9: write beats tick in the same cycle
    step(1'b1, 8'h04, 1'b0, 1'b0);
    step(1'b1, 8'h08, 1'b0, 1'b1);
    chk("R9 tick with write ignored", int'(irqPulse), 0);
    ticks(1);
    chk("R9 first tick after write", int'(irqPulse), 0);
    ticks(1);
    chk("R9 expiry after full reload", int'(irqPulse), 1);

    // R9: read beats tick; R6 service postpones expiry
    step(1'b1, 8'h08, 1'b0, 1'b0);
    ticks(1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R9 tick with read ignored", int'(irqPulse), 0);
    ticks(1);
    chk("R6 serviced countdown not done", int'(irqPulse), 0);
    ticks(1);
    chk("R6 serviced countdown expires", int'(irqPulse), 1);

    // random mix against the model
    for (int i = 0; i < 30000; i++) begin
      logic w, r, t;
      logic [7:0] d;
      w = ($urandom_range(0, 199) == 0);
      r = ($urandom_range(0, 149) == 0);
      t = ($urandom_range(0, 1) == 1);
      d = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 4) != 0) d[1:0] = 2'($urandom_range(0, 1));
      step(w, d, r, t);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule